// File: doc/BRIEF.md
# Status and Interrupt CSR Write Filter

This block is a compact control-and-status register file for a processor's privileged state. It keeps the machine status word, the interrupt-pending and interrupt-enable words, the interrupt and exception delegation words, two three-bit counter-enable words, the supervisor trap vector and a host mailbox word. A single write port (enable, 12-bit address, data) and a single read port (enable, 12-bit address) give access. Every write passes through a per-field filter: fields that software may not change keep their value, an illegal encoding in a checked field leaves that field as it was, and the top status bit is always recomputed from the dirty-state fields.

The supervisor views of status, pending and enable are not separate storage. They reach the machine registers through masks, so a supervisor write only touches the bits that the view exposes or that delegation allows. All stored words are driven out as plain outputs for the rest of the core. A write whose data changes the translation-related status fields raises a one-cycle flush pulse for the address-translation cache. Reads are registered, and a read of an address the block does not hold raises a one-cycle illegal-access flag and returns zero.

Top module: `csr_wfilter`

## Requirements
- R1: While reset is high and on the first cycle after it, every stored word, the flush pulse, the read data and the illegal flag are zero.
- R2: A write to the machine status address (0x300) changes only bits 1, 3, 5, 7, 8, 13-14 (FS), 17 and 18; bits 15-16 (XS) change only when HAS_EXT is 1; all other bits below the top read as zero.
- R3: The translation-mode field (bits 24-28) takes the written value only if it is 0, or 9 or 10 when XLEN is 64, or 8 when XLEN is 32; otherwise it keeps its old value.
- R4: The previous-privilege field (bits 11-12) takes the written value only if it is 0, 1 or 3; the value 2 leaves the field unchanged.
- R5: Bit XLEN-1 of the status word is 1 exactly when FS is 3 or XS is 3.
- R6: One cycle after a write to either status address whose (merged) data differs from the stored word in bits 24-28, 11-12, 17 or 18, the flush output is 1 for one cycle; otherwise it stays 0.
- R7: Writes to pending (0x344) keep only bits 1, 3, 5; to enable (0x304) only bits 1, 3, 5, 7; to interrupt delegation (0x303) only bits 1, 5; to exception delegation (0x302) only the bits of EDELEG_MASK.
- R8: Writes to the supervisor pending (0x144) and enable (0x104) addresses change only bits set in the interrupt delegation word (and in the R7 mask); reads of them return the machine word ANDed with the delegation word.
- R9: A write to the supervisor status address (0x100) changes only bits 1, 5, 8, 13-14, 15-16 and 18 (each still subject to R2); its read returns those bits plus bit XLEN-1.
- R10: A write to the trap vector (0x105) stores the data with bits 0-1 cleared; the user and supervisor counter-enable words (0x320, 0x321) keep the low three bits.
- R11: The host mailbox (0x780) accepts a write only while it holds zero.
- R12: A read sampled with the read enable returns its data on the next cycle; for any address not listed above the data is zero and the illegal flag is 1 for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | XLEN | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read address |
| rd_data | output | XLEN | Read data, one cycle after the strobe |
| rd_illegal | output | 1 | Pulse: read of an unheld address |
| tlb_flush | output | 1 | Pulse: translation fields touched |
| stat_o | output | XLEN | Machine status word |
| ipend_o | output | XLEN | Interrupt-pending word |
| ienab_o | output | XLEN | Interrupt-enable word |
| ideleg_o | output | XLEN | Interrupt delegation word |
| edeleg_o | output | XLEN | Exception delegation word |
| tvec_o | output | XLEN | Supervisor trap vector |
| hostmb_o | output | XLEN | Host mailbox word |
| ucen_o | output | 3 | User counter-enable bits |
| scen_o | output | 3 | Supervisor counter-enable bits |

## Verification
The bench builds the block with XLEN of 64, HAS_EXT of 0 and EDELEG_MASK of 0xFFF. The wide word puts the dirty summary bit at position 63 and makes the 32-bit translation code an illegal value that must be refused while the two 64-bit codes are accepted. With no extension present, all-ones writes through both status views show that the XS field stays zero. The narrow delegation set lets the supervisor pending and enable aliases be driven with all-ones data while only one bit may move.

// File: rtl/csrf_pkg.sv
package csrf_pkg;

    // register addresses
    localparam logic [11:0] A_SSTAT  = 12'h100;
    localparam logic [11:0] A_SIEN   = 12'h104;
    localparam logic [11:0] A_STVEC  = 12'h105;
    localparam logic [11:0] A_SIPND  = 12'h144;
    localparam logic [11:0] A_MSTAT  = 12'h300;
    localparam logic [11:0] A_EDELEG = 12'h302;
    localparam logic [11:0] A_IDELEG = 12'h303;
    localparam logic [11:0] A_MIEN   = 12'h304;
    localparam logic [11:0] A_UCEN   = 12'h320;
    localparam logic [11:0] A_SCEN   = 12'h321;
    localparam logic [11:0] A_MIPND  = 12'h344;
    localparam logic [11:0] A_HOST   = 12'h780;

    // status field positions
    localparam int unsigned MPP_LO = 11;
    localparam int unsigned FS_LO  = 13;
    localparam int unsigned XS_LO  = 15;
    localparam int unsigned VM_LO  = 24;

    // low-word masks, zero extended to XLEN where used
    localparam logic [31:0] ST_FREE_M  = 32'h0006_61AA; // enables, SPP, FS, MPRV, PUM
    localparam logic [31:0] ST_XS_M    = 32'h0001_8000;
    localparam logic [31:0] ST_MPP_M   = 32'h0000_1800;
    localparam logic [31:0] ST_VM_M    = 32'h1F00_0000;
    localparam logic [31:0] ST_SVIEW_M = 32'h0005_E122;
    localparam logic [31:0] ST_FLUSH_M = 32'h1F06_1800;
    localparam logic [31:0] IP_SW_M    = 32'h0000_002A;
    localparam logic [31:0] IE_ALL_M   = 32'h0000_00AA;
    localparam logic [31:0] DELEG_M    = 32'h0000_0022;

    typedef enum logic [4:0] {
        VM_BARE = 5'd0,
        VM_PG32 = 5'd8,
        VM_PG39 = 5'd9,
        VM_PG48 = 5'd10
    } vm_mode_e;

    typedef struct packed {
        logic        en;
        logic [11:0] addr;
    } wr_req_t;

    function automatic logic vm_ok(input logic [4:0] vm, input int unsigned xlen);
        if (vm == VM_BARE) return 1'b1;
        if (xlen == 64) return (vm == VM_PG39) || (vm == VM_PG48);
        if (xlen == 32) return vm == VM_PG32;
        return 1'b0;
    endfunction

    function automatic logic mpp_ok(input logic [1:0] p);
        return p != 2'b10;
    endfunction

endpackage

// File: rtl/csrf_stat_filter.sv
module csrf_stat_filter
    import csrf_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter bit          HAS_EXT = 1'b0
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] req_i,
    output logic [XLEN-1:0] next_o,
    output logic            flush_o
);
    localparam logic [XLEN-1:0] XS_PART = HAS_EXT ? XLEN'(ST_XS_M) : '0;
    localparam logic [XLEN-1:0] FIXED_M = XLEN'(ST_FREE_M) | XS_PART;

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] merged;
    logic            dirty;

    always_comb begin
        mask = FIXED_M;
        if (vm_ok(req_i[VM_LO +: 5], XLEN)) mask = mask | XLEN'(ST_VM_M);
        if (mpp_ok(req_i[MPP_LO +: 2]))     mask = mask | XLEN'(ST_MPP_M);
        merged = (old_i & ~mask) | (req_i & mask);
        dirty  = (merged[FS_LO +: 2] == 2'b11) || (merged[XS_LO +: 2] == 2'b11);
        next_o = merged;
        next_o[XLEN-1] = dirty;
    end

    assign flush_o = |((old_i ^ req_i) & XLEN'(ST_FLUSH_M));

endmodule

// File: rtl/csrf_read_mux.sv
module csrf_read_mux
    import csrf_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [11:0]     addr_i,
    input  logic [XLEN-1:0] stat_i,
    input  logic [XLEN-1:0] ip_i,
    input  logic [XLEN-1:0] ie_i,
    input  logic [XLEN-1:0] ideleg_i,
    input  logic [XLEN-1:0] edeleg_i,
    input  logic [XLEN-1:0] tvec_i,
    input  logic [XLEN-1:0] host_i,
    input  logic [2:0]      ucen_i,
    input  logic [2:0]      scen_i,
    output logic [XLEN-1:0] data_o,
    output logic            hit_o
);
    logic [XLEN-1:0] sview;

    always_comb begin
        sview = stat_i & XLEN'(ST_SVIEW_M);
        sview[XLEN-1] = (stat_i[FS_LO +: 2] == 2'b11) || (stat_i[XS_LO +: 2] == 2'b11);
    end

    always_comb begin
        hit_o  = 1'b1;
        data_o = '0;
        case (addr_i)
            A_SSTAT:  data_o = sview;
            A_SIEN:   data_o = ie_i & ideleg_i;
            A_STVEC:  data_o = tvec_i;
            A_SIPND:  data_o = ip_i & ideleg_i;
            A_MSTAT:  data_o = stat_i;
            A_EDELEG: data_o = edeleg_i;
            A_IDELEG: data_o = ideleg_i;
            A_MIEN:   data_o = ie_i;
            A_UCEN:   data_o = XLEN'(ucen_i);
            A_SCEN:   data_o = XLEN'(scen_i);
            A_MIPND:  data_o = ip_i;
            A_HOST:   data_o = host_i;
            default:  hit_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/csr_wfilter.sv
module csr_wfilter
    import csrf_pkg::*;
#(
    parameter int unsigned     XLEN        = 64,
    parameter bit              HAS_EXT     = 1'b0,
    parameter logic [XLEN-1:0] EDELEG_MASK = XLEN'(32'h0000_0FFF)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            rd_en,
    input  logic [11:0]     rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_illegal,
    output logic            tlb_flush,
    output logic [XLEN-1:0] stat_o,
    output logic [XLEN-1:0] ipend_o,
    output logic [XLEN-1:0] ienab_o,
    output logic [XLEN-1:0] ideleg_o,
    output logic [XLEN-1:0] edeleg_o,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] hostmb_o,
    output logic [2:0]      ucen_o,
    output logic [2:0]      scen_o
);
    localparam logic [XLEN-1:0] SV_M  = XLEN'(ST_SVIEW_M);
    localparam logic [XLEN-1:0] IP_M  = XLEN'(IP_SW_M);
    localparam logic [XLEN-1:0] IE_M  = XLEN'(IE_ALL_M);
    localparam logic [XLEN-1:0] DG_M  = XLEN'(DELEG_M);
    localparam logic [XLEN-1:0] VEC_M = ~XLEN'(3);

    logic [XLEN-1:0] stat_q, ip_q, ie_q, ideleg_q, edeleg_q, tvec_q, host_q;
    logic [2:0]      ucen_q, scen_q;
    logic [XLEN-1:0] rdata_q;
    logic            rill_q, flush_q;

    wr_req_t         req;
    logic            is_stat;
    logic [XLEN-1:0] stat_req, stat_nx;
    logic            stat_fl;
    logic [XLEN-1:0] ip_req, ie_req;
    logic [XLEN-1:0] mux_data;
    logic            mux_hit;

    assign req.en   = wr_en;
    assign req.addr = wr_addr;

    // supervisor aliases merge into the machine words before filtering
    assign is_stat  = (req.addr == A_MSTAT) || (req.addr == A_SSTAT);
    assign stat_req = (req.addr == A_SSTAT) ? ((stat_q & ~SV_M) | (wr_data & SV_M)) : wr_data;
    assign ip_req   = (req.addr == A_SIPND) ? ((ip_q & ~ideleg_q) | (wr_data & ideleg_q)) : wr_data;
    assign ie_req   = (req.addr == A_SIEN)  ? ((ie_q & ~ideleg_q) | (wr_data & ideleg_q)) : wr_data;

    csrf_stat_filter #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_stat (
        .old_i   (stat_q),
        .req_i   (stat_req),
        .next_o  (stat_nx),
        .flush_o (stat_fl)
    );

    csrf_read_mux #(.XLEN(XLEN)) u_rmux (
        .addr_i   (rd_addr),
        .stat_i   (stat_q),
        .ip_i     (ip_q),
        .ie_i     (ie_q),
        .ideleg_i (ideleg_q),
        .edeleg_i (edeleg_q),
        .tvec_i   (tvec_q),
        .host_i   (host_q),
        .ucen_i   (ucen_q),
        .scen_i   (scen_q),
        .data_o   (mux_data),
        .hit_o    (mux_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            ip_q     <= '0;
            ie_q     <= '0;
            ideleg_q <= '0;
            edeleg_q <= '0;
            tvec_q   <= '0;
            host_q   <= '0;
            ucen_q   <= '0;
            scen_q   <= '0;
            flush_q  <= 1'b0;
        end else begin
            flush_q <= req.en && is_stat && stat_fl;
            if (req.en) begin
                case (req.addr)
                    A_MSTAT, A_SSTAT: stat_q   <= stat_nx;
                    A_MIPND, A_SIPND: ip_q     <= (ip_q & ~IP_M) | (ip_req & IP_M);
                    A_MIEN,  A_SIEN:  ie_q     <= (ie_q & ~IE_M) | (ie_req & IE_M);
                    A_IDELEG:         ideleg_q <= wr_data & DG_M;
                    A_EDELEG:         edeleg_q <= wr_data & EDELEG_MASK;
                    A_STVEC:          tvec_q   <= wr_data & VEC_M;
                    A_UCEN:           ucen_q   <= wr_data[2:0];
                    A_SCEN:           scen_q   <= wr_data[2:0];
                    A_HOST: begin
                        if (host_q == '0) host_q <= wr_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            rill_q  <= 1'b0;
        end else begin
            rill_q <= rd_en && !mux_hit;
            if (rd_en) rdata_q <= mux_hit ? mux_data : '0;
        end
    end

    assign rd_data    = rdata_q;
    assign rd_illegal = rill_q;
    assign tlb_flush  = flush_q;
    assign stat_o     = stat_q;
    assign ipend_o    = ip_q;
    assign ienab_o    = ie_q;
    assign ideleg_o   = ideleg_q;
    assign edeleg_o   = edeleg_q;
    assign tvec_o     = tvec_q;
    assign hostmb_o   = host_q;
    assign ucen_o     = ucen_q;
    assign scen_o     = scen_q;

endmodule

// File: rtl/csrf_chk.sv
module csrf_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            rd_en,
    input logic [XLEN-1:0] rd_data,
    input logic            rd_illegal,
    input logic            tlb_flush,
    input logic [XLEN-1:0] stat_o,
    input logic [XLEN-1:0] ipend_o,
    input logic [XLEN-1:0] ideleg_o,
    input logic [XLEN-1:0] tvec_o,
    input logic [XLEN-1:0] hostmb_o
);
    // R5
    sd_summary_chk: assert property (@(posedge clk) disable iff (rst)
        stat_o[XLEN-1] == ((stat_o[14:13] == 2'b11) || (stat_o[16:15] == 2'b11)));

    // R4
    mpp_legal_chk: assert property (@(posedge clk) disable iff (rst)
        stat_o[12:11] != 2'b10);

    // R6
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tlb_flush |-> $past(wr_en));

    // R7
    ipend_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (ipend_o & ~XLEN'(32'h2A)) == '0);

    // R7
    ideleg_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (ideleg_o & ~XLEN'(32'h22)) == '0);

    // R10
    tvec_align_chk: assert property (@(posedge clk) disable iff (rst)
        tvec_o[1:0] == 2'b00);

    // R11
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hostmb_o != '0) |=> $stable(hostmb_o));

    // R12
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_illegal |-> ($past(rd_en) && rd_data == '0));

endmodule

bind csr_wfilter csrf_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .tlb_flush  (tlb_flush),
    .stat_o     (stat_o),
    .ipend_o    (ipend_o),
    .ideleg_o   (ideleg_o),
    .tvec_o     (tvec_o),
    .hostmb_o   (hostmb_o)
);

// File: tb/csr_wfilter_test.sv
module csr_wfilter_test;
    localparam int unsigned XLEN = 64;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic            rd_en = 1'b0;
    logic [11:0]     rd_addr = '0;
    logic [XLEN-1:0] rd_data;
    logic            rd_illegal, tlb_flush;
    logic [XLEN-1:0] stat_o, ipend_o, ienab_o, ideleg_o, edeleg_o, tvec_o, hostmb_o;
    logic [2:0]      ucen_o, scen_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    csr_wfilter #(.XLEN(XLEN), .HAS_EXT(1'b0), .EDELEG_MASK(64'hFFF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_illegal(rd_illegal),
        .tlb_flush(tlb_flush), .stat_o(stat_o), .ipend_o(ipend_o), .ienab_o(ienab_o),
        .ideleg_o(ideleg_o), .edeleg_o(edeleg_o), .tvec_o(tvec_o), .hostmb_o(hostmb_o),
        .ucen_o(ucen_o), .scen_o(scen_o)
    );

    logic [63:0] exp_q[$];
    bit          ill_q[$];
    string       tag_q[$];
    bit          sampled = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input bit exp_fl);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tlb_flush == exp_fl, "R6 flush pulse", 64'(tlb_flush), 64'(exp_fl));
    endtask

    task automatic rd(input logic [11:0] a, input logic [63:0] exp, input bit ill, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); ill_q.push_back(ill); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) sampled <= rd_en;

    always @(negedge clk) begin
        #1;
        if (sampled && exp_q.size() > 0) begin
            logic [63:0] e;
            bit          il;
            string       t;
            e = exp_q.pop_front(); il = ill_q.pop_front(); t = tag_q.pop_front();
            chk(rd_data == e, t, rd_data, e);
            chk(rd_illegal == il, {t, " illegal flag"}, 64'(rd_illegal), 64'(il));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(stat_o == 0 && ipend_o == 0 && ienab_o == 0 && hostmb_o == 0 && tvec_o == 0,
            "R1 reset words", stat_o | ipend_o | ienab_o | hostmb_o | tvec_o, 64'h0);
        chk(tlb_flush == 0 && rd_illegal == 0 && rd_data == 0, "R1 reset pulses",
            64'(tlb_flush) | 64'(rd_illegal) | rd_data, 64'h0);
        rst = 1'b0;
        rd(12'h300, 64'h0, 1'b0, "R1 status read after reset");

        // R2 R3 R4 R5: all ones, VM=31 refused, MPP=3 taken, XS blocked
        wr(12'h300, ONES, 1'b1);
        chk(stat_o == 64'h8000_0000_0006_79AA, "R2 status all-ones filter", stat_o, 64'h8000_0000_0006_79AA);
        // same translation fields: no flush
        wr(12'h300, 64'h8000_0000_0006_79AA, 1'b0);
        chk(stat_o == 64'h8000_0000_0006_79AA, "R5 status rewrite", stat_o, 64'h8000_0000_0006_79AA);
        // VM=9 legal, MPP=2 refused, FS cleared so SD drops
        wr(12'h300, 64'h0000_0000_0900_1000, 1'b1);
        chk(stat_o == 64'h0000_0000_0900_1800, "R4 MPP=2 kept old, R3 VM=9", stat_o, 64'h0000_0000_0900_1800);
        // VM=8 illegal at 64 bits
        wr(12'h300, 64'h0000_0000_0800_0000, 1'b1);
        chk(stat_o == 64'h0000_0000_0900_0000, "R3 VM=8 refused", stat_o, 64'h0000_0000_0900_0000);
        wr(12'h300, 64'h0000_0000_0A00_0000, 1'b1);
        chk(stat_o == 64'h0000_0000_0A00_0000, "R3 VM=10 taken", stat_o, 64'h0000_0000_0A00_0000);

        // R9 supervisor status alias
        wr(12'h100, ONES, 1'b1);
        chk(stat_o == 64'h8000_0000_0A04_6122, "R9 supervisor status write", stat_o, 64'h8000_0000_0A04_6122);
        rd(12'h100, 64'h8000_0000_0004_6122, 1'b0, "R9 supervisor status read");

        // R7 masks
        wr(12'h303, ONES, 1'b0);
        chk(ideleg_o == 64'h22, "R7 delegation mask", ideleg_o, 64'h22);
        wr(12'h303, 64'h20, 1'b0);
        wr(12'h344, ONES, 1'b0);
        chk(ipend_o == 64'h2A, "R7 pending mask", ipend_o, 64'h2A);
        wr(12'h344, 64'h08, 1'b0);
        chk(ipend_o == 64'h08, "R7 pending write", ipend_o, 64'h08);

        // R8 supervisor pending / enable
        wr(12'h144, ONES, 1'b0);
        chk(ipend_o == 64'h28, "R8 sip write delegated only", ipend_o, 64'h28);
        rd(12'h144, 64'h20, 1'b0, "R8 sip read");
        wr(12'h104, ONES, 1'b0);
        chk(ienab_o == 64'h20, "R8 sie write delegated only", ienab_o, 64'h20);
        rd(12'h104, 64'h20, 1'b0, "R8 sie read");
        wr(12'h304, ONES, 1'b0);
        chk(ienab_o == 64'hAA, "R7 enable mask", ienab_o, 64'hAA);
        wr(12'h302, ONES, 1'b0);
        chk(edeleg_o == 64'hFFF, "R7 exception delegation mask", edeleg_o, 64'hFFF);

        // R10 vector and counter enables
        wr(12'h105, 64'h1237, 1'b0);
        chk(tvec_o == 64'h1234, "R10 vector low bits", tvec_o, 64'h1234);
        rd(12'h105, 64'h1234, 1'b0, "R10 vector read");
        wr(12'h320, 64'hFF, 1'b0);
        wr(12'h321, 64'h5A, 1'b0);
        chk(ucen_o == 3'd7 && scen_o == 3'd2, "R10 counter enables", {58'h0, ucen_o, scen_o}, 64'h3A);
        rd(12'h321, 64'h2, 1'b0, "R10 counter enable read");

        // R11 mailbox
        wr(12'h780, 64'h55, 1'b0);
        chk(hostmb_o == 64'h55, "R11 mailbox first write", hostmb_o, 64'h55);
        wr(12'h780, 64'h66, 1'b0);
        chk(hostmb_o == 64'h55, "R11 mailbox write refused", hostmb_o, 64'h55);
        rd(12'h780, 64'h55, 1'b0, "R11 mailbox read");

        // R12 unknown address
        rd(12'h7FF, 64'h0, 1'b1, "R12 unknown read");
        @(negedge clk); #2;
        chk(rd_illegal == 1'b0, "R12 illegal flag one cycle", 64'(rd_illegal), 64'h0);
        rd(12'h300, 64'h8000_0000_0A04_6122, 1'b0, "R12 status read after illegal");

        @(negedge clk); #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule